// File: doc/BRIEF.md
# BCD Time-of-Day Alarm Comparator

This block holds a set of programmed alarm bytes and compares them against the current calendar time. The calendar time comes from an external timekeeping chain as BCD seconds, minutes, hours, day of month and month. The timekeeping chain also supplies a one-cycle strobe after each seconds increment. The comparison runs only on that strobe. When every alarm field agrees with the current time, the block raises a single-cycle match pulse on the following cycle. That pulse is meant for the interrupt flag logic. Only 24-hour BCD time is supported.

Software programs the alarm through a byte-wide register port. The port has a write strobe, a 3-bit address and a combinational read path. Any field whose two top bits are both set is a wildcard, so 0xFF means "match any value".

The day-of-month alarm uses only its low six bits. A value of zero in those bits also acts as a wildcard. The day and month fields together allow an alarm up to a year ahead. Each of those two fields can be removed by a parameter. A removed field always matches, its address ignores writes, and it reads as zero.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset every implemented alarm field holds 0xFF (the day field therefore reads 0x3F) and `match_pulse` is low.
- R2: A write with `reg_we` high stores `reg_wdata` into the field at `reg_addr`. The field codes are 0 seconds, 1 minutes, 2 hours, 3 day of month and 4 month. `reg_rdata` returns the stored byte for codes 0, 1, 2 and 4 in the same cycle the address is presented.
- R3: Reading code 3 returns only the low six bits of the stored day byte, with bits 7:6 read as zero.
- R4: `match_pulse` is high for exactly the one cycle after a cycle with `sec_tick` high in which all fields matched. It is low in every other cycle, so there is at most one pulse per tick.
- R5: A seconds, minutes, hours or month field that is not a wildcard matches only when it equals the current BCD byte exactly. A value outside the BCD range, such as 0x75, therefore never matches.
- R6: A field whose bits 7:6 are both 1 (any value 0xC0 to 0xFF) matches every current value.
- R7: The day field compares its low six bits against the current day and ignores its bits 7:6 unless both are set. When its low six bits are zero it matches any day.
- R8: A write in the same cycle as `sec_tick` does not affect that comparison. The new value is used from the next tick on.
- R9: With `HAS_DAY` or `HAS_MON` set to 0, the corresponding field always matches, writes to its code are ignored, and it reads as 0x00.
- R10: Codes 5 to 7 ignore writes and read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle strobe after each seconds increment |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD, 24-hour |
| cur_mday | input | 8 | Current day of month, BCD |
| cur_mon | input | 8 | Current month, BCD |
| reg_we | input | 1 | Alarm register write strobe |
| reg_addr | input | 3 | Alarm field code |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational readback of the addressed field |
| match_pulse | output | 1 | One-cycle alarm match |

## Verification
A corrupted alarm byte shows up on `reg_rdata` as soon as its code is addressed. If no read happens, it shows up as a missing or extra `match_pulse` one cycle after the next `sec_tick`. A wrong wildcard decode or day-bit mask cannot be seen at readback. It shows only in the match pulse, and only when the current time differs from the stored field in the bits that are wrongly decoded. For that reason the bench moves one field of the time at a time. A reference model is compared against both a full instance and a reduced instance on every clock.

// File: rtl/rtc_alm_pkg.sv
package rtc_alm_pkg;

  typedef enum logic [2:0] {
    FLD_SEC  = 3'd0,
    FLD_MIN  = 3'd1,
    FLD_HOUR = 3'd2,
    FLD_MDAY = 3'd3,
    FLD_MON  = 3'd4
  } alm_field_e;

  localparam int unsigned FIELD_CNT = 5;
  localparam logic [7:0]  RESET_CODE = 8'hFF;

  // top two bits set marks "match anything"
  function automatic logic is_wild(input logic [7:0] v);
    return v[7:6] == 2'b11;
  endfunction

  // day field keeps only its low six bits visible
  function automatic logic [7:0] day_view(input logic [7:0] v);
    return {2'b00, v[5:0]};
  endfunction

  function automatic logic field_hit(input logic is_day,
                                     input logic [7:0] alm,
                                     input logic [7:0] cur);
    if (is_wild(alm)) return 1'b1;
    if (is_day) return (alm[5:0] == 6'd0) || (day_view(alm) == cur);
    return alm == cur;
  endfunction

endpackage

// File: rtl/alm_regfile.sv
module alm_regfile
  import rtc_alm_pkg::*;
#(
  parameter int unsigned FIELDS  = FIELD_CNT,
  parameter int unsigned ADDR_W  = 3,
  parameter logic [FIELDS-1:0] PRESENT = '1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [7:0]                 wdata,
  output logic [FIELDS-1:0][7:0]     regs,
  output logic [7:0]                 rdata
);

  for (genvar i = 0; i < FIELDS; i++) begin : g_fld
    if (PRESENT[i]) begin : g_on
      always_ff @(posedge clk) begin
        if (!rst_n)
          regs[i] <= RESET_CODE;
        else if (we && (addr == ADDR_W'(i)))
          regs[i] <= wdata;
      end
    end else begin : g_off
      assign regs[i] = 8'h00;
    end
  end

  always_comb begin
    rdata = 8'h00;
    for (int i = 0; i < FIELDS; i++) begin
      if (PRESENT[i] && (addr == ADDR_W'(i))) begin
        if (i == int'(FLD_MDAY)) rdata = day_view(regs[i]);
        else                     rdata = regs[i];
      end
    end
  end

endmodule

// File: rtl/alm_field_cmp.sv
module alm_field_cmp
  import rtc_alm_pkg::*;
#(
  parameter bit IS_DAY = 1'b0
) (
  input  logic [7:0] alm,
  input  logic [7:0] cur,
  output logic       hit
);

  assign hit = field_hit(IS_DAY, alm, cur);

endmodule

// File: rtl/alm_match_reg.sv
module alm_match_reg #(
  parameter int unsigned FIELDS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [FIELDS-1:0] hits,
  output logic              pulse
);

  always_ff @(posedge clk) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= tick & (&hits);
  end

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alm_pkg::*;
#(
  parameter bit          HAS_DAY = 1'b1,
  parameter bit          HAS_MON = 1'b1,
  parameter int unsigned ADDR_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic [7:0]        cur_sec,
  input  logic [7:0]        cur_min,
  input  logic [7:0]        cur_hour,
  input  logic [7:0]        cur_mday,
  input  logic [7:0]        cur_mon,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              match_pulse
);

  localparam int unsigned FIELDS = FIELD_CNT;
  localparam logic [FIELDS-1:0] PRESENT = {HAS_MON, HAS_DAY, 3'b111};

  logic [FIELDS-1:0][7:0] alm_regs;
  logic [FIELDS-1:0][7:0] cur_vec;
  logic [FIELDS-1:0]      field_hit_w;

  assign cur_vec = {cur_mon, cur_mday, cur_hour, cur_min, cur_sec};

  alm_regfile #(
    .FIELDS (FIELDS),
    .ADDR_W (ADDR_W),
    .PRESENT(PRESENT)
  ) i_regs (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (reg_we),
    .addr (reg_addr),
    .wdata(reg_wdata),
    .regs (alm_regs),
    .rdata(reg_rdata)
  );

  for (genvar i = 0; i < FIELDS; i++) begin : g_cmp
    if (PRESENT[i]) begin : g_on
      alm_field_cmp #(
        .IS_DAY(i == int'(FLD_MDAY))
      ) i_cmp (
        .alm(alm_regs[i]),
        .cur(cur_vec[i]),
        .hit(field_hit_w[i])
      );
    end else begin : g_off
      assign field_hit_w[i] = 1'b1;
    end
  end

  alm_match_reg #(
    .FIELDS(FIELDS)
  ) i_match (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (sec_tick),
    .hits (field_hit_w),
    .pulse(match_pulse)
  );

endmodule

// File: rtl/rtc_alarm_match_chk.sv
module rtc_alarm_match_chk #(
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sec_tick,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [7:0]        reg_rdata,
  input logic [4:0]        field_hit_w,
  input logic              match_pulse
);

  a_r4_pulse_follows_tick: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> $past(sec_tick));

  a_r4_full_hit_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && (&field_hit_w)) |=> match_pulse);

  a_r4_miss_is_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !(&field_hit_w)) |=> !match_pulse);

  a_r3_day_top_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(3)) |-> (reg_rdata[7:6] == 2'b00));

  a_r6_wild_seconds_hit: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_addr == ADDR_W'(0)) && (reg_rdata[7:6] == 2'b11)) |-> field_hit_w[0]);

  a_r10_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr > ADDR_W'(4)) |-> (reg_rdata == 8'h00));

endmodule

bind rtc_alarm_match rtc_alarm_match_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sec_tick   (sec_tick),
  .reg_addr   (reg_addr),
  .reg_rdata  (reg_rdata),
  .field_hit_w(field_hit_w),
  .match_pulse(match_pulse)
);

// File: tb/test_rtc_alarm_match.sv
module test_rtc_alarm_match;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic [7:0] cur_sec = 8'h00, cur_min = 8'h00, cur_hour = 8'h00;
  logic [7:0] cur_mday = 8'h01, cur_mon = 8'h01;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] rdata_full, rdata_lite;
  logic       pulse_full, pulse_lite;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  string tag = "R1";
  int mdl [5];

  always #4 clk = ~clk;

  rtc_alarm_match i_rtc_alarm_match (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_mday(cur_mday), .cur_mon(cur_mon),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata_full), .match_pulse(pulse_full)
  );

  rtc_alarm_match #(.HAS_DAY(1'b0), .HAS_MON(1'b0)) i_rtc_alarm_match_lite (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_mday(cur_mday), .cur_mon(cur_mon),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata_lite), .match_pulse(pulse_lite)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference: wildcard if value >= 0xC0; day uses value mod 64, zero = any
  function automatic bit ref_match(input bit full);
    int now [5];
    bit ok = 1;
    now[0] = cur_sec; now[1] = cur_min; now[2] = cur_hour;
    now[3] = cur_mday; now[4] = cur_mon;
    for (int f = 0; f < 5; f++) begin
      if (f >= 3 && !full) continue;
      if (mdl[f] >= 'hC0) continue;
      if (f == 3) begin
        if ((mdl[f] % 64) != 0 && (mdl[f] % 64) != now[f]) ok = 0;
      end else if (mdl[f] != now[f]) ok = 0;
    end
    return ok;
  endfunction

  task automatic step();
    bit e_full, e_lite;
    @(posedge clk);
    e_full = sec_tick && ref_match(1);
    e_lite = sec_tick && ref_match(0);
    if (!rst_n) begin
      e_full = 0; e_lite = 0;
      for (int f = 0; f < 5; f++) mdl[f] = 'hFF;
    end else if (reg_we && reg_addr < 5) mdl[reg_addr] = reg_wdata;
    #2;
    check({tag, " R4 pulse full"}, pulse_full, e_full);
    check({tag, " R4 pulse reduced"}, pulse_lite, e_lite);
  endtask

  task automatic wr(input int a, input int d);
    reg_we = 1; reg_addr = 3'(a); reg_wdata = 8'(d);
    step();
    reg_we = 0;
  endtask

  task automatic rd(input string req, input int a, input int ef, input int el);
    reg_addr = 3'(a);
    #1;
    check({req, " read full"}, rdata_full, ef);
    check({req, " read reduced"}, rdata_lite, el);
  endtask

  task automatic tick_at(input int s, input int m, input int h, input int d, input int mo);
    cur_sec = 8'(s); cur_min = 8'(m); cur_hour = 8'(h);
    cur_mday = 8'(d); cur_mon = 8'(mo);
    sec_tick = 1;
    step();
    sec_tick = 0;
    step();
    step();
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;
    tag = "R1";
    step();
    check("R1 pulse idle", pulse_full, 0);
    rd("R1", 0, 'hFF, 'hFF);
    rd("R1", 2, 'hFF, 'hFF);
    rd("R1", 3, 'h3F, 'h00);
    rd("R9", 4, 'hFF, 'h00);
    tag = "R6";
    tick_at('h12, 'h34, 'h05, 'h09, 'h11);
    tag = "R2";
    wr(0, 'h30); wr(1, 'h15); wr(2, 'h23); wr(3, 'h17); wr(4, 'h08);
    rd("R2", 0, 'h30, 'h30);
    rd("R2", 1, 'h15, 'h15);
    rd("R2", 2, 'h23, 'h23);
    rd("R2", 4, 'h08, 'h00);
    rd("R3", 3, 'h17, 'h00);
    tag = "R5";
    tick_at('h30, 'h15, 'h23, 'h17, 'h08);
    tick_at('h31, 'h15, 'h23, 'h17, 'h08);
    tick_at('h30, 'h16, 'h23, 'h17, 'h08);
    tick_at('h30, 'h15, 'h22, 'h17, 'h08);
    tick_at('h30, 'h15, 'h23, 'h17, 'h09);
    tag = "R9";
    tick_at('h30, 'h15, 'h23, 'h18, 'h08);
    tag = "R7";
    wr(3, 'h57);
    rd("R3", 3, 'h17, 'h00);
    tick_at('h30, 'h15, 'h23, 'h17, 'h08);
    wr(3, 'h40);
    rd("R7", 3, 'h00, 'h00);
    tick_at('h30, 'h15, 'h23, 'h05, 'h08);
    tag = "R6";
    wr(4, 'hC3);
    tick_at('h30, 'h15, 'h23, 'h28, 'h11);
    wr(2, 'hE0);
    tick_at('h30, 'h15, 'h07, 'h28, 'h12);
    tag = "R8";
    cur_sec = 'h30;
    sec_tick = 1;
    wr(0, 'h45);
    sec_tick = 0;
    step();
    tick_at('h30, 'h15, 'h07, 'h28, 'h12);
    tick_at('h45, 'h15, 'h07, 'h28, 'h12);
    tag = "R5";
    wr(0, 'h75);
    tick_at('h59, 'h15, 'h07, 'h28, 'h12);
    tick_at('h75, 'h15, 'h07, 'h28, 'h12);
    tag = "R10";
    wr(5, 'h12);
    rd("R10", 5, 'h00, 'h00);
    rd("R10", 7, 'h00, 'h00);
    rd("R10", 0, 'h75, 'h75);
    tag = "R4";
    cur_sec = 'h75;
    step(); step();
    sec_tick = 1; step(); step(); sec_tick = 0; step();
    tag = "R1";
    rst_n = 0; step(); rst_n = 1;
    rd("R1", 0, 'hFF, 'hFF);
    rd("R1", 3, 'h3F, 'h00);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule